// File: doc/BRIEF.md
# Fixed-Latency Word Memory

This block is a small on-chip byte array of 1024 bytes that serves one 32-bit word request at a time. A requester offers a request made of an operation code, a byte address and write data. The memory takes the request when it is idle and holds it for a fixed number of cycles. It then carries out a read, a write, or a read followed by a write at the addressed location, and offers a response made of an error flag and read data. The requester takes the response with a ready signal, and only then can the next request enter.

Reset loads the array with a known pattern: each byte holds its own address modulo 256. Words are little-endian and need not be aligned. An access whose four bytes do not all lie inside the array is refused with an error and leaves the contents untouched. The block fits in a trace-driven model of a core that blocks on every fetch, load, store or atomic swap.

Top module: `fixed_lat_mem`

## Requirements
- R1: After reset, byte i of the array holds i modulo 256. A word reads little-endian, with the byte at the lowest address in bits 7:0, so a fetch at address 0 returns 0x03020100.
- R2: `reqReady` is high only while the block is idle. A request is taken on a clock edge where `reqValid` and `reqReady` are both high. No further request is taken until the response has been taken.
- R3: `rspValid` rises exactly LATENCY clock edges after the edge that took the request. A LATENCY of 0 behaves as a LATENCY of 1.
- R4: While `rspValid` is high and `rspReady` is low, `rspValid`, `rspData` and `rspError` hold their values. The response is taken on an edge where both are high.
- R5: Operation code 0 (fetch) and code 1 (load) return the four bytes at the address and do not change the array.
- R6: Operation code 2 (store) writes the four request data bytes at the address, little-endian. Its response data is zero.
- R7: Operation code 3 (atomic swap) returns the content held before the access and writes the request data in the same access.
- R8: An address above 1020 (MEM_BYTES minus 4) returns error 1 and data zero and changes no byte. Every other address returns error 0.
- R9: Operation codes 4 to 15 neither read nor write the array. They return data zero, with the error flag set by the address rule of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset; also loads the array pattern |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | The block is idle and takes a request |
| reqType | input | TYPE_W (4) | Operation code: 0 fetch, 1 load, 2 store, 3 atomic swap |
| reqAddr | input | ADDR_W (32) | Byte address of the word |
| reqData | input | DATA_W (32) | Write data for store and swap |
| rspValid | output | 1 | A response is offered |
| rspReady | input | 1 | The requester takes the response |
| rspError | output | 1 | The access fell outside the array |
| rspData | output | DATA_W (32) | Read data, zero when nothing was read |

## Verification
The hardest case to reach from the ports is an out-of-range write that would have landed partly inside the array, such as a store at address 1021, because the refusal only shows if the bytes it would have hit are read back afterwards. The bench issues such a store and then loads the last in-range word, expecting the reset pattern. The atomic swap is checked by storing a known word first, so that the old content returned can be told apart from the reset pattern and from the new data, which a following load must return. The zero-latency case runs on a second instance built with LATENCY set to 0, where the bench counts edges from acceptance to response.

// File: rtl/fxm_pkg.sv
package fxm_pkg;

  // Operation codes carried on reqType
  localparam int OP_FETCH = 0;
  localparam int OP_LOAD  = 1;
  localparam int OP_STORE = 2;
  localparam int OP_SWAP  = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the offered request
    logic access;   // perform the array access and load the response
  } memStrobe_t;

endpackage

// File: rtl/fxm_ctrl.sv
module fxm_ctrl
  import fxm_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       rspValid,
  input  logic       rspReady,
  output memStrobe_t strobe
);

  localparam int EFF_LAT = (LATENCY < 1) ? 1 : LATENCY;
  localparam int CNT_W   = $clog2(EFF_LAT + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RESP
  } ctrlState_t;

  ctrlState_t state;
  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state   <= ST_WAIT;
            waitCnt <= CNT_W'(EFF_LAT - 1);
          end
        end
        ST_WAIT: begin
          if (waitCnt == '0) begin
            state <= ST_RESP;
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        ST_RESP: begin
          if (rspReady) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady       = (state == ST_IDLE);
    rspValid       = (state == ST_RESP);
    strobe.capture = (state == ST_IDLE) && reqValid;
    strobe.access  = (state == ST_WAIT) && (waitCnt == '0);
  end

endmodule

// File: rtl/fxm_datapath.sv
module fxm_datapath
  import fxm_pkg::*;
#(
  parameter int TYPE_W    = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MEM_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [TYPE_W-1:0] reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              rspError,
  output logic [DATA_W-1:0] rspData
);

  localparam int IDX_W      = $clog2(MEM_BYTES);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int LAST_OK    = MEM_BYTES - WORD_BYTES;

  logic [TYPE_W-1:0] typeQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [7:0]        memArr [MEM_BYTES];

  logic              inRange;
  logic              doRead;
  logic              doWrite;
  logic [IDX_W-1:0]  baseIdx;
  logic [DATA_W-1:0] oldWord;

  // Request holding registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      typeQ <= '0;
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobe.capture) begin
      typeQ <= reqType;
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  always_comb begin
    inRange = (addrQ <= ADDR_W'(LAST_OK));
    doRead  = (typeQ == TYPE_W'(OP_FETCH)) || (typeQ == TYPE_W'(OP_LOAD)) ||
              (typeQ == TYPE_W'(OP_SWAP));
    doWrite = (typeQ == TYPE_W'(OP_STORE)) || (typeQ == TYPE_W'(OP_SWAP));
    baseIdx = addrQ[IDX_W-1:0];
  end

  // Little-endian gather of the addressed word, one lane per byte
  for (genvar lane = 0; lane < WORD_BYTES; lane++) begin : g_rdLane
    assign oldWord[8*lane +: 8] = memArr[baseIdx + IDX_W'(lane)];
  end

  // Byte array with its power-on pattern
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) begin
        memArr[i] <= 8'(i);
      end
    end else if (strobe.access && doWrite && inRange) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        memArr[baseIdx + IDX_W'(b)] <= dataQ[8*b +: 8];
      end
    end
  end

  // Response registers; read data is the content before the write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspError <= 1'b0;
      rspData  <= '0;
    end else if (strobe.access) begin
      rspError <= !inRange;
      rspData  <= (doRead && inRange) ? oldWord : '0;
    end
  end

endmodule

// File: rtl/fixed_lat_mem.sv
module fixed_lat_mem
  import fxm_pkg::*;
#(
  parameter int TYPE_W    = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MEM_BYTES = 1024,
  parameter int LATENCY   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [TYPE_W-1:0] reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic              rspError,
  output logic [DATA_W-1:0] rspData
);

  memStrobe_t strobe;

  fxm_ctrl #(
    .LATENCY(LATENCY)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .strobe   (strobe)
  );

  fxm_datapath #(
    .TYPE_W    (TYPE_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MEM_BYTES (MEM_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqType  (reqType),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .rspError (rspError),
    .rspData  (rspData)
  );

endmodule

// File: rtl/fxm_chk.sv
module fxm_chk #(
  parameter int TYPE_W    = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MEM_BYTES = 1024,
  parameter int LATENCY   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [TYPE_W-1:0] reqType,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspReady,
  input logic              rspError,
  input logic [DATA_W-1:0] rspData
);

  localparam int EFF_LAT = (LATENCY < 1) ? 1 : LATENCY;
  localparam int LAST_OK = MEM_BYTES - DATA_W / 8;

  int                sinceAcc;
  logic [ADDR_W-1:0] lastAddr;
  logic [TYPE_W-1:0] lastType;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAcc <= 0;
      lastAddr <= '0;
      lastType <= '0;
    end else if (reqValid && reqReady) begin
      sinceAcc <= 0;
      lastAddr <= reqAddr;
      lastType <= reqType;
    end else if (!rspValid && !reqReady) begin
      sinceAcc <= sinceAcc + 1;
    end
  end

  // R2
  alternation_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && rspValid));

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> (sinceAcc == EFF_LAT));

  // R4
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData) && $stable(rspError)));

  // R8
  bounds_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspError == (lastAddr > ADDR_W'(LAST_OK))));

  // R8
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspError) |-> (rspData == '0));

  // R6
  store_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && lastType == TYPE_W'(2)) |-> (rspData == '0));

endmodule

bind fixed_lat_mem fxm_chk #(
  .TYPE_W    (TYPE_W),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .MEM_BYTES (MEM_BYTES),
  .LATENCY   (LATENCY)
) u_fxm_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqType  (reqType),
  .reqAddr  (reqAddr),
  .rspValid (rspValid),
  .rspReady (rspReady),
  .rspError (rspError),
  .rspData  (rspData)
);

// File: tb/test_fixed_lat_mem.sv
module test_fixed_lat_mem;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [3:0]  reqType = '0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic        rspError;
  logic [31:0] rspData;

  logic        zReqValid = 1'b0;
  logic        zReqReady;
  logic        zRspValid;
  logic        zRspReady = 1'b0;
  logic        zRspError;
  logic [31:0] zRspData;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  fixed_lat_mem #(.LATENCY(LAT)) i_fixed_lat_mem (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqType(reqType), .reqAddr(reqAddr), .reqData(reqData),
    .rspValid(rspValid), .rspReady(rspReady), .rspError(rspError), .rspData(rspData)
  );

  fixed_lat_mem #(.LATENCY(0)) i_fixed_lat_mem_zero (
    .clk(clk), .rstN(rstN), .reqValid(zReqValid), .reqReady(zReqReady),
    .reqType(4'd1), .reqAddr(32'd8), .reqData(32'd0),
    .rspValid(zRspValid), .rspReady(zRspReady), .rspError(zRspError), .rspData(zRspData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // One complete transaction; returns error, data and measured latency
  task automatic doReq(input logic [3:0] t, input logic [31:0] a, input logic [31:0] d,
                       output logic err, output logic [31:0] rd, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqType = t; reqAddr = a; reqData = d;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R2 busy after accept", 32'(reqReady), 32'd0);
    lat = 0;
    while (!rspValid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    err = rspError;
    rd  = rspData;
    // hold the response for two cycles
    repeat (2) @(negedge clk);
    check(rspValid && rspData == rd && rspError == err, "R4 response held",
          rspData, rd);
    check(reqReady == 1'b0, "R2 no accept while response pending", 32'(reqReady), 32'd0);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    check(!rspValid && reqReady, "R4 response taken", 32'(rspValid), 32'd0);
  endtask

  task automatic expectReq(input string req, input logic [3:0] t, input logic [31:0] a,
                           input logic [31:0] d, input logic expErr, input logic [31:0] expData);
    logic e; logic [31:0] r; int l;
    doReq(t, a, d, e, r, l);
    check(l == LAT, {req, " R3 latency"}, 32'(l), 32'(LAT));
    check(e == expErr, {req, " error"}, 32'(e), 32'(expErr));
    check(r == expData, {req, " data"}, r, expData);
  endtask

  task automatic testReset;
    @(negedge clk);
    check(reqReady == 1'b1, "R2 idle after reset", 32'(reqReady), 32'd1);
    check(rspValid == 1'b0, "R4 no response after reset", 32'(rspValid), 32'd0);
    expectReq("R1 fetch addr 0", 4'd0, 32'd0, 32'd0, 1'b0, 32'h03020100);
    expectReq("R1 R5 load addr 64", 4'd1, 32'd64, 32'd0, 1'b0, 32'h43424140);
    expectReq("R5 load unaligned 253", 4'd1, 32'd253, 32'd0, 1'b0, 32'h00FFFEFD);
    expectReq("R8 load last word 1020", 4'd1, 32'd1020, 32'd0, 1'b0, 32'hFFFEFDFC);
  endtask

  task automatic testStore;
    expectReq("R6 store 100", 4'd2, 32'd100, 32'hDEADBEEF, 1'b0, 32'h0);
    expectReq("R6 load after store", 4'd1, 32'd100, 32'd0, 1'b0, 32'hDEADBEEF);
    expectReq("R6 neighbour 104 intact", 4'd0, 32'd104, 32'd0, 1'b0, 32'h6B6A6968);
  endtask

  task automatic testSwap;
    expectReq("R7 swap returns old", 4'd3, 32'd100, 32'h11223344, 1'b0, 32'hDEADBEEF);
    expectReq("R7 load after swap", 4'd1, 32'd100, 32'd0, 1'b0, 32'h11223344);
  endtask

  task automatic testBounds;
    expectReq("R8 store 1021 refused", 4'd2, 32'd1021, 32'hA5A5A5A5, 1'b1, 32'h0);
    expectReq("R8 word 1020 unchanged", 4'd1, 32'd1020, 32'd0, 1'b0, 32'hFFFEFDFC);
    expectReq("R8 swap far address", 4'd3, 32'hFFFFFFFC, 32'h12345678, 1'b1, 32'h0);
    expectReq("R8 load 1024", 4'd1, 32'd1024, 32'd0, 1'b1, 32'h0);
  endtask

  task automatic testUnknownOp;
    expectReq("R9 code 5 no access", 4'd5, 32'd200, 32'h55555555, 1'b0, 32'h0);
    expectReq("R9 code 15 out of range", 4'd15, 32'd2000, 32'h0, 1'b1, 32'h0);
    expectReq("R9 word 200 unchanged", 4'd1, 32'd200, 32'd0, 1'b0, 32'hCBCAC9C8);
  endtask

  task automatic testZeroLatency;
    int l;
    @(negedge clk);
    zReqValid = 1'b1;
    while (!zReqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    zReqValid = 1'b0;
    l = 0;
    while (!zRspValid && l < 100) begin
      @(negedge clk);
      l++;
    end
    check(l == 1, "R3 LATENCY 0 acts as 1", 32'(l), 32'd1);
    check(zRspData == 32'h0B0A0908 && !zRspError, "R5 zero-latency load data",
          zRspData, 32'h0B0A0908);
    zRspReady = 1'b1;
    @(negedge clk);
    zRspReady = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStore();
    testSwap();
    testBounds();
    testUnknownOp();
    testZeroLatency();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule